// File: doc/BRIEF.md
# PWM Channel with Double-Buffered Parameter Update

This block is a single pulse-width modulation channel. A free-running period counter, a duty comparator and a pair of dead-time generators drive a complementary high-side and low-side output pair. The period, the duty and the two dead-time values each have two copies: a shadow copy that is written while the channel runs, and an active copy that the waveform logic uses. A shadow value moves into its active copy only at an update point, so the output never shows a half-applied setting.

The update point depends on how the channel is configured. A stand-alone channel applies its pending values at the end of every period. A channel in a synchronous group waits for a manual unlock request before it applies period and dead-time values. The duty value follows the selected update method. In method 0 it also waits for unlock. In the automatic methods it waits until an update-period counter, advanced once per PWM period, wraps at its programmed reload value. The active values are brought out so that a host can see what the waveform is using.

Top module: `pwm_shadow_chan`

## Requirements
- R1: With channel enable high, the counter runs from 0 to active period minus 1. `period_end` is high in that last count, and the counter restarts at 0. A period value of P gives a P-cycle PWM period.
- R2: With `sync_mode` low, every pending shadow value is copied to its active register at the clock edge that ends the current period. Active values never change at any other edge.
- R3: With `sync_mode` high and `upd_method` = 0, pending period, duty and dead-time values are held until an unlock request has been made. They then transfer at the next end of period.
- R4: With `sync_mode` high and `upd_method` at 1, 2 or 3, pending period and dead-time values need an unlock request and an end of period before they transfer.
- R5: With `sync_mode` high and `upd_method` at 1, 2 or 3, a pending duty value transfers only at an end of period in which the update-period counter equals `upr_value`. That counter then wraps to 0; at every other end of period it increments by one. After one wrap, the next duty transfer therefore comes `upr_value`+1 periods later.
- R6: When a shadow register is written several times between two transfers, only the most recent value is applied.
- R7: A one-cycle `unlock_pulse` sets a sticky unlock flag in the next cycle. The flag clears at the next end of period, so a later write again needs a fresh unlock.
- R8: A parameter with no pending write keeps its active value across any number of update points.
- R9: The high output follows counter < active duty and the low output follows its complement, both one cycle late. Each rising edge is delayed by a further dead-time count of its own (`dt_hi`, `dt_lo`), so the high output is on for duty minus dt_hi cycles per period. The two outputs are never high together.
- R10: With channel enable low, the counter holds at 0, `period_end` stays low and both outputs are low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel run enable |
| sync_mode | input | 1 | 1 = channel is part of a synchronous group |
| upd_method | input | 2 | Update method for synchronous mode (0 manual, 1 to 3 automatic duty) |
| unlock_pulse | input | 1 | One-cycle unlock request |
| upr_value | input | UPR_W | Reload value of the update-period counter |
| per_wr | input | 1 | Shadow period write strobe |
| per_wdata | input | CNT_W | Shadow period data |
| duty_wr | input | 1 | Shadow duty write strobe |
| duty_wdata | input | CNT_W | Shadow duty data |
| dth_wr | input | 1 | Shadow high-side dead-time write strobe |
| dth_wdata | input | DT_W | Shadow high-side dead-time data |
| dtl_wr | input | 1 | Shadow low-side dead-time write strobe |
| dtl_wdata | input | DT_W | Shadow low-side dead-time data |
| period_end | output | 1 | High in the last count of each period |
| pwm_hi | output | 1 | High-side output |
| pwm_lo | output | 1 | Low-side output |
| act_period | output | CNT_W | Active period value |
| act_duty | output | CNT_W | Active duty value |
| act_dt_hi | output | DT_W | Active high-side dead-time |
| act_dt_lo | output | DT_W | Active low-side dead-time |

## Verification
The assertions assume that write strobes and `unlock_pulse` are single-cycle pulses. They also assume that the mode inputs `sync_mode` and `upd_method` are changed only away from an update point. The stimulus drives every strobe for exactly one cycle and changes modes and writes registers only just after a period boundary. It keeps duty strictly between the two dead-times and the period, so that both outputs always have a visible on phase. No write falls in the same cycle as `period_end`, which keeps the transfer ordering unambiguous.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  // Update method encoding for a channel of a synchronous group.
  typedef enum logic [1:0] {
    UPD_LOCKED = 2'd0,   // all parameters wait for unlock
    UPD_AUTO_A = 2'd1,   // duty follows update-period counter
    UPD_AUTO_B = 2'd2,   // same gating as UPD_AUTO_A
    UPD_AUTO_C = 2'd3    // treated as automatic
  } upd_mode_e;

  function automatic logic duty_follows_unlock(input upd_mode_e m);
    return (m == UPD_LOCKED);
  endfunction

endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int CNT_W = 8,
  parameter int UPR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic [CNT_W-1:0] act_period,
  input  logic [UPR_W-1:0] upr_value,
  output logic [CNT_W-1:0] cnt,
  output logic             period_end,
  output logic             upd_wrap
);

  logic [CNT_W-1:0] cnt_nxt;
  logic [UPR_W-1:0] upd_cnt, upd_cnt_nxt;

  // last count reached; a period of 0 behaves like 1
  assign period_end = chan_en && (({1'b0, cnt} + 1'b1) >= {1'b0, act_period});
  assign upd_wrap   = period_end && (upd_cnt >= upr_value);

  always_comb begin
    cnt_nxt = cnt + 1'b1;
    if (!chan_en || period_end) cnt_nxt = '0;
  end

  always_comb begin
    upd_cnt_nxt = upd_cnt;
    if (upd_wrap)        upd_cnt_nxt = '0;
    else if (period_end) upd_cnt_nxt = upd_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      upd_cnt <= '0;
    end else begin
      cnt     <= cnt_nxt;
      upd_cnt <= upd_cnt_nxt;
    end
  end

endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         xfer,
  output logic [W-1:0] active
);

  logic [W-1:0] shadow, shadow_nxt, active_nxt;
  logic         pending, pending_nxt;
  logic         take;

  assign take = xfer && pending;

  always_comb begin
    shadow_nxt  = wr_en ? wr_data : shadow;
    active_nxt  = take ? shadow : active;
    pending_nxt = wr_en || (pending && !xfer);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= RST_VAL;
      active  <= RST_VAL;
      pending <= 1'b0;
    end else begin
      shadow  <= shadow_nxt;
      active  <= active_nxt;
      pending <= pending_nxt;
    end
  end

endmodule

// File: rtl/pwm_deadtime.sv
module pwm_deadtime #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw,
  input  logic [DT_W-1:0] dt,
  output logic            out
);

  logic [DT_W-1:0] dly, dly_nxt;
  logic            out_nxt;

  always_comb begin
    dly_nxt = dly;
    out_nxt = 1'b0;
    if (!raw) begin
      dly_nxt = '0;
    end else if (dly >= dt) begin
      out_nxt = 1'b1;
    end else begin
      dly_nxt = dly + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly <= '0;
      out <= 1'b0;
    end else begin
      dly <= dly_nxt;
      out <= out_nxt;
    end
  end

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DT_W       = 4,
  parameter int UPR_W      = 4,
  parameter int RST_PERIOD = 16,
  parameter int RST_DUTY   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             sync_mode,
  input  logic [1:0]       upd_method,
  input  logic             unlock_pulse,
  input  logic [UPR_W-1:0] upr_value,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic             dth_wr,
  input  logic [DT_W-1:0]  dth_wdata,
  input  logic             dtl_wr,
  input  logic [DT_W-1:0]  dtl_wdata,
  output logic             period_end,
  output logic             pwm_hi,
  output logic             pwm_lo,
  output logic [CNT_W-1:0] act_period,
  output logic [CNT_W-1:0] act_duty,
  output logic [DT_W-1:0]  act_dt_hi,
  output logic [DT_W-1:0]  act_dt_lo
);

  localparam int NUM_SIDES = 2;
  localparam logic [CNT_W-1:0] RST_P = CNT_W'(RST_PERIOD);
  localparam logic [CNT_W-1:0] RST_D = CNT_W'(RST_DUTY);

  logic [CNT_W-1:0] cnt;
  logic             upd_wrap;
  logic             unlock_req, unlock_req_nxt;
  logic             pd_xfer, duty_xfer, duty_gate;
  logic             cmp_hi;
  upd_mode_e        mode;

  logic [NUM_SIDES-1:0] raw_v, out_v;
  logic [DT_W-1:0]      dt_v [NUM_SIDES];

  assign mode = upd_mode_e'(upd_method);

  pwm_period_timer #(.CNT_W(CNT_W), .UPR_W(UPR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .act_period (act_period),
    .upr_value  (upr_value),
    .cnt        (cnt),
    .period_end (period_end),
    .upd_wrap   (upd_wrap)
  );

  // sticky unlock request, consumed by the next end of period
  always_comb begin
    unlock_req_nxt = unlock_req;
    if (period_end)   unlock_req_nxt = 1'b0;
    if (unlock_pulse) unlock_req_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlock_req <= 1'b0;
    else        unlock_req <= unlock_req_nxt;
  end

  // update gating policies
  always_comb begin
    if (!sync_mode)                     duty_gate = 1'b1;
    else if (duty_follows_unlock(mode)) duty_gate = unlock_req;
    else                                duty_gate = upd_wrap;
  end

  assign pd_xfer   = period_end && (!sync_mode || unlock_req);
  assign duty_xfer = period_end && duty_gate;

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL(RST_P)) u_per (
    .clk(clk), .rst_n(rst_n), .wr_en(per_wr), .wr_data(per_wdata),
    .xfer(pd_xfer), .active(act_period)
  );

  pwm_shadow_reg #(.W(CNT_W), .RST_VAL(RST_D)) u_duty (
    .clk(clk), .rst_n(rst_n), .wr_en(duty_wr), .wr_data(duty_wdata),
    .xfer(duty_xfer), .active(act_duty)
  );

  pwm_shadow_reg #(.W(DT_W), .RST_VAL('0)) u_dth (
    .clk(clk), .rst_n(rst_n), .wr_en(dth_wr), .wr_data(dth_wdata),
    .xfer(pd_xfer), .active(act_dt_hi)
  );

  pwm_shadow_reg #(.W(DT_W), .RST_VAL('0)) u_dtl (
    .clk(clk), .rst_n(rst_n), .wr_en(dtl_wr), .wr_data(dtl_wdata),
    .xfer(pd_xfer), .active(act_dt_lo)
  );

  // complementary raw waveform
  assign cmp_hi   = (cnt < act_duty);
  assign raw_v[0] = chan_en && cmp_hi;
  assign raw_v[1] = chan_en && !cmp_hi;
  assign dt_v[0]  = act_dt_hi;
  assign dt_v[1]  = act_dt_lo;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    pwm_deadtime #(.DT_W(DT_W)) u_dt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_v[s]),
      .dt    (dt_v[s]),
      .out   (out_v[s])
    );
  end

  assign pwm_hi = out_v[0];
  assign pwm_lo = out_v[1];

endmodule

// File: rtl/pwm_shadow_chan_chk.sv
module pwm_shadow_chan_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             sync_mode,
  input logic             unlock_pulse,
  input logic             unlock_req,
  input logic             period_end,
  input logic             pwm_hi,
  input logic             pwm_lo,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_period,
  input logic [CNT_W-1:0] act_duty
);

  // R1: counter restarts after the last count
  a_r1_restart_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt == '0));

  // R2: active values move only at an update point
  a_r2_duty_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(act_duty));

  // R3: synchronous period held while no unlock is pending
  a_r3_period_held_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !unlock_req) |=> $stable(act_period));

  // R7: unlock request is captured
  a_r7_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pulse |=> unlock_req);

  // R9: complementary outputs never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_hi && pwm_lo));

  // R10: disabled channel drives both outputs low
  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!pwm_hi && !pwm_lo));

endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .chan_en      (chan_en),
  .sync_mode    (sync_mode),
  .unlock_pulse (unlock_pulse),
  .unlock_req   (unlock_req),
  .period_end   (period_end),
  .pwm_hi       (pwm_hi),
  .pwm_lo       (pwm_lo),
  .cnt          (cnt),
  .act_period   (act_period),
  .act_duty     (act_duty)
);

// File: tb/pwm_shadow_chan_tb.sv
`timescale 1ns/100ps
module pwm_shadow_chan_tb;

  localparam int CNT_W = 8;
  localparam int DT_W  = 4;
  localparam int UPR_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             chan_en, sync_mode, unlock_pulse;
  logic [1:0]       upd_method;
  logic [UPR_W-1:0] upr_value;
  logic             per_wr, duty_wr, dth_wr, dtl_wr;
  logic [CNT_W-1:0] per_wdata, duty_wdata;
  logic [DT_W-1:0]  dth_wdata, dtl_wdata;
  logic             period_end, pwm_hi, pwm_lo;
  logic [CNT_W-1:0] act_period, act_duty;
  logic [DT_W-1:0]  act_dt_hi, act_dt_lo;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_shadow_chan #(.CNT_W(CNT_W), .DT_W(DT_W), .UPR_W(UPR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sync_mode(sync_mode),
    .upd_method(upd_method), .unlock_pulse(unlock_pulse), .upr_value(upr_value),
    .per_wr(per_wr), .per_wdata(per_wdata), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
    .dth_wr(dth_wr), .dth_wdata(dth_wdata), .dtl_wr(dtl_wr), .dtl_wdata(dtl_wdata),
    .period_end(period_end), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .act_period(act_period), .act_duty(act_duty),
    .act_dt_hi(act_dt_hi), .act_dt_lo(act_dt_lo)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // encodings: 0 period, 1 duty, 2 high dead-time, 3 low dead-time
  task automatic write_reg(input int which, input int val);
    @(negedge clk);
    case (which)
      0: begin per_wr  = 1'b1; per_wdata  = CNT_W'(val); end
      1: begin duty_wr = 1'b1; duty_wdata = CNT_W'(val); end
      2: begin dth_wr  = 1'b1; dth_wdata  = DT_W'(val);  end
      default: begin dtl_wr = 1'b1; dtl_wdata = DT_W'(val); end
    endcase
    @(negedge clk);
    per_wr = 1'b0; duty_wr = 1'b0; dth_wr = 1'b0; dtl_wr = 1'b0;
  endtask

  task automatic pulse_unlock();
    @(negedge clk);
    unlock_pulse = 1'b1;
    @(negedge clk);
    unlock_pulse = 1'b0;
  endtask

  // returns in the first cycle of a new period
  task automatic next_boundary();
    @(negedge clk);
    while (!period_end) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 reset period", int'(act_period), 16);
    check("R10 reset duty", int'(act_duty), 8);
    check("R10 reset hi", int'(pwm_hi), 0);
    check("R10 reset lo", int'(pwm_lo), 0);
    check("R10 reset end", int'(period_end), 0);
  endtask

  task automatic t_async_setup();
    int n;
    chan_en = 1'b1;
    sync_mode = 1'b0;
    next_boundary();
    write_reg(0, 20);
    write_reg(1, 8);
    write_reg(2, 2);
    write_reg(3, 3);
    check("R2 mid-period hold period", int'(act_period), 16);
    check("R2 mid-period hold duty", int'(act_duty), 8);
    next_boundary();
    check("R2 period applied", int'(act_period), 20);
    check("R2 dt_hi applied", int'(act_dt_hi), 2);
    check("R2 dt_lo applied", int'(act_dt_lo), 3);
    // R1 period length
    n = 1;
    while (!period_end) begin @(negedge clk); n++; end
    check("R1 period length", n, 20);
    next_boundary();
    check("R8 period unchanged", int'(act_period), 20);
  endtask

  task automatic t_waveform();
    int hi_cnt = 0;
    int lo_cnt = 0;
    next_boundary();
    for (int i = 0; i < 20; i++) begin
      if (pwm_hi) hi_cnt++;
      if (pwm_lo) lo_cnt++;
      @(negedge clk);
    end
    check("R9 hi on-time", hi_cnt, 6);
    check("R9 lo on-time", lo_cnt, 9);
  endtask

  task automatic t_last_write();
    next_boundary();
    write_reg(1, 3);
    write_reg(1, 7);
    write_reg(1, 9);
    check("R2 duty held mid-period", int'(act_duty), 8);
    next_boundary();
    check("R6 last write wins", int'(act_duty), 9);
  endtask

  task automatic t_method0();
    next_boundary();
    sync_mode = 1'b1;
    upd_method = 2'd0;
    write_reg(1, 12);
    write_reg(0, 30);
    write_reg(2, 1);
    next_boundary();
    next_boundary();
    check("R3 duty held", int'(act_duty), 9);
    check("R3 period held", int'(act_period), 20);
    check("R3 dt held", int'(act_dt_hi), 2);
    pulse_unlock();
    check("R3 held before end", int'(act_duty), 9);
    next_boundary();
    check("R3 duty after unlock", int'(act_duty), 12);
    check("R3 period after unlock", int'(act_period), 30);
    check("R3 dt after unlock", int'(act_dt_hi), 1);
    write_reg(1, 4);
    next_boundary();
    next_boundary();
    check("R7 unlock consumed", int'(act_duty), 12);
    sync_mode = 1'b0;
    next_boundary();
    check("R2 async releases", int'(act_duty), 4);
  endtask

  task automatic t_method1();
    int k;
    next_boundary();
    sync_mode = 1'b1;
    upd_method = 2'd1;
    upr_value = 4'd2;
    write_reg(1, 5);
    k = 0;
    while (act_duty != 8'd5 && k < 8) begin next_boundary(); k++; end
    check("R5 first duty applied", int'(act_duty), 5);
    write_reg(1, 11);
    write_reg(0, 24);
    k = 0;
    while (act_duty != 8'd11 && k < 8) begin
      next_boundary();
      k++;
    end
    check("R5 boundaries to duty wrap", k, 3);
    check("R4 period held without unlock", int'(act_period), 30);
    pulse_unlock();
    next_boundary();
    check("R4 period after unlock", int'(act_period), 24);
    check("R8 duty unchanged", int'(act_duty), 11);
  endtask

  task automatic t_disable();
    chan_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 hi low", int'(pwm_hi), 0);
    check("R10 lo low", int'(pwm_lo), 0);
    check("R10 no end", int'(period_end), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    chan_en = 1'b0; sync_mode = 1'b0; upd_method = 2'd0; unlock_pulse = 1'b0;
    upr_value = '0;
    per_wr = 1'b0; duty_wr = 1'b0; dth_wr = 1'b0; dtl_wr = 1'b0;
    per_wdata = '0; duty_wdata = '0; dth_wdata = '0; dtl_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_async_setup();
    t_waveform();
    t_last_write();
    t_method0();
    t_method1();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule